// File: doc/BRIEF.md
# Dual-Slot Transmit Buffer Controller

This block is a 32-bit register-bus slave holding two transmit slots. Each slot has a frame buffer of 509 words, a length register and a control register. One global interrupt-enable register is shared by both slots. Software fills a slot's buffer, writes its length, then writes its control register. That one control write either streams the slot's frame out as bytes or loads a 48-bit station address from the first six bytes of the slot. When the operation finishes, the block issues a one-cycle interrupt pulse, gated per slot and globally.

The bus uses word addresses only, and every access is a full 32-bit word. Writes take effect at the clock edge on which `bus_wr` is high. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.

The byte stream is valid/ready. `tx_valid` stays high from the first byte of a frame to the last. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. A byte transfers on each clock edge where both are high. One engine serves both slots. A start written to one slot while the other is streaming waits until that frame ends.

Top module: `txbuf_ctrl`

## Requirements
- R1: After reset, `tx_valid` and `irq` are 0 and `station_addr` is 0. Every length and control register reads 0.
- R2: A control write with bit 0 = 1 and bit 1 = 0 streams the number of bytes held in that slot's length register. Bytes start at the slot's first byte, lowest byte lane (bits 7:0) of each word first. `tx_last` is 1 on the final byte only.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` hold their values in the next cycle.
- R4: Control readback is {bit 3 = interrupt enable, bit 1 = program, bit 0 = start}, with all other bits 0. Bit 0 reads 1 while the slot's operation is pending or running. Bits 1 and 0 read 0 after it completes.
- R5: Any control write to a slot whose bit 0 is 1 is ignored entirely. This includes its interrupt-enable bit, so the running frame is sent exactly once.
- R6: A control write with bits 1:0 = 2'b11 loads `station_addr` from the slot's first six bytes, byte 0 in bits 7:0 up to byte 5 in bits 47:40. No byte is streamed.
- R7: Each completed operation produces exactly one one-cycle `irq` pulse when the slot's control bit 3 and global bit 31 are both 1. No pulse is produced otherwise.
- R8: The global interrupt-enable register is at word 0x1FE (byte offset 0x7F8). Only bit 31 is stored, and it reads back alone. The same position in slot 1 (word 0x3FE) ignores writes and reads 0.
- R9: The length register holds 11 bits. Written values above 2036 (0x7F4) are stored as 2036. A start with length 0 completes without streaming a byte.
- R10: A start written to one slot while the other slot is streaming is served after the current frame ends.
- R11: A control write with bit 0 = 0 starts nothing. It stores bit 3, and bit 0 and bit 1 read back 0.
- R12: Buffer words read back as written. Slot 0 occupies words 0x000–0x1FC, with length at 0x1FD and control at 0x1FF. Slot 1 occupies words 0x200–0x3FC, with length at 0x3FD and control at 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| station_addr | output | 48 | Programmed station address |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Some faults show on the first streamed byte or the first read: a wrong lane or word pointer gives a wrong byte, and a lost busy flag lets an ignored start repeat the frame. Both appear on the first compared byte, or as leftover or surplus bytes once the slot reads idle. A stuck start bit keeps control bit 0 at 1, which the polling read catches within its timeout. A wrong gate or completion flag gives a wrong interrupt pulse count, checked a few cycles after each completion. A bad latch on the station address shows on `station_addr` two cycles after the control write.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic {ENG_IDLE, ENG_SEND} eng_state_e;
  localparam int CTL_GO   = 0;
  localparam int CTL_PROG = 1;
  localparam int CTL_IE   = 3;
  localparam int GIE_BIT  = 31;
endpackage

// File: rtl/txb_regs.sv
module txb_regs #(
  parameter int WADDR_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [WADDR_W-1:0]           bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [1:0]                   go_o,
  output logic [1:0]                   prog_o,
  output logic [1:0]                   ie_o,
  output logic                         gie_o,
  output logic [1:0][WADDR_W:0]        len_o,
  input  logic                         done_i,
  input  logic                         done_slot_i,
  input  logic                         eng_slot_i,
  input  logic [WADDR_W-2:0]           eng_word_i,
  output logic [31:0]                  eng_data_o,
  output logic [47:0]                  eng_head_o
);
  import txb_pkg::*;
  localparam int WIDX_W     = WADDR_W - 1;
  localparam int LEN_W      = WADDR_W + 1;
  localparam int SLOT_WORDS = 2 ** WIDX_W;
  localparam int BUF_WORDS  = SLOT_WORDS - 3;
  localparam logic [WIDX_W-1:0] LEN_IDX  = WIDX_W'(SLOT_WORDS - 3);
  localparam logic [WIDX_W-1:0] GIE_IDX  = WIDX_W'(SLOT_WORDS - 2);
  localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(SLOT_WORDS - 1);
  localparam logic [LEN_W-1:0]  BUF_BYTES = LEN_W'(BUF_WORDS * 4);

  logic [31:0] mem [2][BUF_WORDS];
  logic              slot;
  logic [WIDX_W-1:0] widx;
  logic              is_buf, is_ctrl;

  assign slot    = bus_addr[WADDR_W-1];
  assign widx    = bus_addr[WIDX_W-1:0];
  assign is_buf  = widx < WIDX_W'(BUF_WORDS);
  assign is_ctrl = widx == CTRL_IDX;

  always_ff @(posedge clk) begin
    if (bus_wr && is_buf) mem[slot][widx] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_o <= '0; prog_o <= '0; ie_o <= '0; gie_o <= 1'b0; len_o <= '0;
    end else begin
      if (done_i) begin
        go_o[done_slot_i]   <= 1'b0;
        prog_o[done_slot_i] <= 1'b0;
      end
      if (bus_wr && is_ctrl && !go_o[slot]) begin
        ie_o[slot] <= bus_wdata[CTL_IE];
        if (bus_wdata[CTL_GO]) begin
          go_o[slot]   <= 1'b1;
          prog_o[slot] <= bus_wdata[CTL_PROG];
        end
      end
      if (bus_wr && widx == LEN_IDX)
        len_o[slot] <= (bus_wdata > 32'(BUF_BYTES)) ? BUF_BYTES : bus_wdata[LEN_W-1:0];
      if (bus_wr && widx == GIE_IDX && !slot) gie_o <= bus_wdata[GIE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (is_buf)                      bus_rdata <= mem[slot][widx];
      else if (widx == LEN_IDX)        bus_rdata <= {{(32-LEN_W){1'b0}}, len_o[slot]};
      else if (widx == GIE_IDX && !slot) bus_rdata <= {gie_o, 31'b0};
      else if (is_ctrl)                bus_rdata <= {28'b0, ie_o[slot], 1'b0, prog_o[slot], go_o[slot]};
      else                             bus_rdata <= '0;
    end
  end

  assign eng_data_o = mem[eng_slot_i][eng_word_i];
  assign eng_head_o = {mem[eng_slot_i][1][15:0], mem[eng_slot_i][0]};

  // R5
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && is_ctrl && go_o[slot] |=> ie_o == $past(ie_o));
endmodule

// File: rtl/txb_engine.sv
module txb_engine #(
  parameter int WADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            go_i,
  input  logic [1:0]            prog_i,
  input  logic [1:0]            ie_i,
  input  logic                  gie_i,
  input  logic [1:0][WADDR_W:0] len_i,
  output logic                  eng_slot_o,
  output logic [WADDR_W-2:0]    eng_word_o,
  input  logic [31:0]           eng_data_i,
  input  logic [47:0]           eng_head_i,
  output logic                  done_o,
  output logic                  done_slot_o,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  output logic [47:0]           station_o,
  output logic                  irq_o
);
  import txb_pkg::*;
  localparam int LEN_W = WADDR_W + 1;

  eng_state_e       st;
  logic             cur, pick;
  logic [LEN_W-1:0] cnt, len_q;

  assign pick       = go_i[0] ? 1'b0 : 1'b1;
  assign eng_slot_o = (st == ENG_SEND) ? cur : pick;
  assign eng_word_o = cnt[LEN_W-1:2];
  assign tx_valid   = (st == ENG_SEND);
  assign tx_data    = eng_data_i[8*cnt[1:0] +: 8];
  assign tx_last    = tx_valid && (cnt == len_q - LEN_W'(1));

  always_comb begin
    done_o      = 1'b0;
    done_slot_o = pick;
    if (st == ENG_IDLE && |go_i && (prog_i[pick] || len_i[pick] == '0))
      done_o = 1'b1;
    if (st == ENG_SEND && tx_ready && tx_last) begin
      done_o      = 1'b1;
      done_slot_o = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; cur <= 1'b0; cnt <= '0; len_q <= '0;
      station_o <= '0; irq_o <= 1'b0;
    end else begin
      irq_o <= done_o && ie_i[done_slot_o] && gie_i;
      case (st)
        ENG_IDLE: if (|go_i) begin
          if (prog_i[pick]) station_o <= eng_head_i;
          else if (len_i[pick] != '0) begin
            st <= ENG_SEND; cur <= pick; cnt <= '0; len_q <= len_i[pick];
          end
        end
        ENG_SEND: if (tx_ready) begin
          if (tx_last) st <= ENG_IDLE;
          else         cnt <= cnt + LEN_W'(1);
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie_i));
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl #(
  parameter int WADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  output logic [47:0]        station_addr,
  output logic               irq
);
  logic [1:0]            go, prog, ie;
  logic                  gie, done, done_slot, eng_slot;
  logic [1:0][WADDR_W:0] len;
  logic [WADDR_W-2:0]    eng_word;
  logic [31:0]           eng_data;
  logic [47:0]           eng_head;

  txb_regs #(.WADDR_W(WADDR_W)) regs_i (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .go_o(go), .prog_o(prog), .ie_o(ie), .gie_o(gie), .len_o(len),
    .done_i(done), .done_slot_i(done_slot), .eng_slot_i(eng_slot),
    .eng_word_i(eng_word), .eng_data_o(eng_data), .eng_head_o(eng_head));

  txb_engine #(.WADDR_W(WADDR_W)) eng_i (
    .clk, .rst_n, .go_i(go), .prog_i(prog), .ie_i(ie), .gie_i(gie), .len_i(len),
    .eng_slot_o(eng_slot), .eng_word_o(eng_word), .eng_data_i(eng_data),
    .eng_head_i(eng_head), .done_o(done), .done_slot_o(done_slot),
    .tx_valid, .tx_ready, .tx_data, .tx_last, .station_o(station_addr), .irq_o(irq));

  // R4
  stream_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> |go);
endmodule

// File: tb/txbuf_ctrl_tb_top.sv
module txbuf_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b1, tx_last, irq;
  logic [7:0]  tx_data;
  logic [47:0] station_addr;

  int n_cmp = 0, n_bad = 0, irq_cnt = 0;
  int bp_mode = 0;
  logic [8:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  txbuf_ctrl dut_i (.*);

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lfsr[0] : 1'b0;
  end

  logic       held_v = 1'b0;
  logic [8:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (held_v) begin
        n_cmp++;
        if (!tx_valid || {tx_last, tx_data} != held) begin
          n_bad++;
          $display("FAIL R3 stalled byte changed: got %h/%0d exp %h", {tx_last, tx_data}, tx_valid, held);
        end
      end
      held_v = tx_valid && !tx_ready;
      held   = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected byte %h last %0d exp none", tx_data, tx_last);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if ({tx_last, tx_data} != e) begin
            n_bad++;
            $display("FAIL R2 byte got %h exp %h", {tx_last, tx_data}, e);
          end
        end
      end
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(int waddr, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 10'(waddr); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(int waddr, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 10'(waddr);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed * 37 + k * 11 + (k >> 3));
  endfunction

  task automatic fill(int slot, int seed, int n);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(slot * 512 + w, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic expect_frame(int seed, int n);
    for (int k = 0; k < n; k++) exp_q.push_back({(k == n - 1), pat(seed, k)});
  endtask

  task automatic wait_idle(int slot);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(slot * 512 + 511, d);
      if (!d[0]) break;
    end
    check("R4 bits 1:0 clear after completion", 64'(d[1:0]), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int slot, int seed, int n, logic ie);
    fill(slot, seed, n);
    wr(slot * 512 + 509, 32'(n));
    expect_frame(seed, n);
    wr(slot * 512 + 511, {28'b0, ie, 3'b001});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired before end of test");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int i0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", 64'(tx_valid), 0);
    check("R1 irq", 64'(irq), 0);
    check("R1 station_addr", 64'(station_addr), 0);
    rd(511, d); check("R1 ctrl0", 64'(d), 0);
    rd(1021, d); check("R1 len1", 64'(d), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 global enable, only bit 31
    wr(510, 32'hFFFF_FFFF); rd(510, d); check("R8 gie readback", 64'(d), 64'h8000_0000);
    wr(1022, 32'hFFFF_FFFF); rd(1022, d); check("R8 slot1 gie hole", 64'(d), 0);

    // R12 buffer readback
    wr(512 + 508, 32'hDEAD_BEEF); rd(512 + 508, d); check("R12 buffer word", 64'(d), 64'hDEAD_BEEF);

    // R2 / R7 basic send, free-running sink
    i0 = irq_cnt;
    send(0, 1, 7, 1'b1); wait_idle(0);
    check("R2 frame fully drained", 64'(exp_q.size()), 0);
    check("R7 one irq", 64'(irq_cnt - i0), 1);
    rd(511, d); check("R4 ctrl after send", 64'(d), 64'h8);

    // R3 random backpressure, slot 1, odd length
    bp_mode = 1; i0 = irq_cnt;
    send(1, 2, 45, 1'b1); wait_idle(1);
    check("R3 frame drained under stall", 64'(exp_q.size()), 0);
    check("R7 irq slot1", 64'(irq_cnt - i0), 1);

    // R5 busy start ignored, R4 busy readback
    bp_mode = 2; i0 = irq_cnt;
    send(0, 3, 12, 1'b1);
    rd(511, d); check("R4 busy reads bit0", 64'(d), 64'h9);
    wr(511, 32'h1);
    rd(511, d); check("R5 busy write ignored", 64'(d), 64'h9);
    bp_mode = 0; wait_idle(0);
    check("R5 frame sent once", 64'(exp_q.size()), 0);
    check("R5 ie kept, irq", 64'(irq_cnt - i0), 1);

    // R10 other slot queued behind current frame
    bp_mode = 2; i0 = irq_cnt;
    send(0, 4, 9, 1'b1);
    send(1, 5, 6, 1'b1);
    bp_mode = 1; wait_idle(0); wait_idle(1);
    check("R10 both frames in order", 64'(exp_q.size()), 0);
    check("R10 two irqs", 64'(irq_cnt - i0), 2);

    // R6 program station address, no bytes streamed
    i0 = irq_cnt;
    wr(512, 32'h4433_2211); wr(513, 32'hAAAA_6655);
    wr(1023, 32'hB);
    wait_idle(1);
    check("R6 station addr", 64'(station_addr), 64'h6655_4433_2211);
    check("R6 irq on program", 64'(irq_cnt - i0), 1);

    // R7 per-slot enable off
    i0 = irq_cnt;
    send(0, 6, 5, 1'b0); wait_idle(0);
    check("R7 no irq when slot ie 0", 64'(irq_cnt - i0), 0);

    // R7 global enable off
    wr(510, 32'h0); i0 = irq_cnt;
    send(1, 7, 3, 1'b1); wait_idle(1);
    check("R7 no irq when gie 0", 64'(irq_cnt - i0), 0);
    wr(510, 32'h8000_0000);

    // R9 zero length and clamp
    i0 = irq_cnt;
    wr(509, 32'h0); wr(511, 32'h9); wait_idle(0);
    check("R9 zero length no bytes", 64'(exp_q.size()), 0);
    check("R9 zero length irq", 64'(irq_cnt - i0), 1);
    wr(509, 32'hFFF); rd(509, d); check("R9 length clamp", 64'(d), 64'h7F4);

    // R11 control without start
    i0 = irq_cnt;
    wr(1023, 32'hA); repeat (4) @(negedge clk);
    rd(1023, d); check("R11 ctrl no start", 64'(d), 64'h8);
    check("R11 no irq", 64'(irq_cnt - i0), 0);
    check("R11 no byte", 64'(tx_valid), 0);
    check("R11 station unchanged", 64'(station_addr), 64'h6655_4433_2211);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule